// File: doc/BRIEF.md
# Ticket lock unit

A central mutual-exclusion service shared by a fixed number of requesters. Each requester owns one acquire pulse, one release pulse and one grant line. An acquire draws a ticket from a dispensing counter. The counter is read and bumped as a single atomic step. The unit owns the lock on behalf of whichever requester holds the ticket that matches its service counter. Because tickets are handed out in arrival order and service moves forward one ticket per release, ownership passes strictly first come, first served.

A requester pulses its acquire input once and then waits for its grant line. It works inside the protected region while the grant is high. It then pulses release, which hands the lock to the next ticket holder. A release from a requester that is not the current owner changes nothing and is reported on a one-cycle error output.

Top module: `ticket_lock_unit`

## Requirements
- R1: Out of reset both counters are zero, no grant is high and the error output is low, so the first accepted acquire receives ticket 0.
- R2: An acquire from a requester holding no ticket is accepted. It receives the current dispenser value, and the dispenser advances by the number of acquires accepted in that cycle.
- R3: A requester's grant is high exactly while it holds a ticket equal to the service counter. It rises in the cycle after the clock edge that accepted the acquire if the lock is free at that point.
- R4: At most one grant line is high in any cycle.
- R5: A release from the grant holder advances the service counter by one. The holder's grant falls after that edge, and in the same cycle the holder of the next ticket sees its grant rise. A requester that is not releasing keeps its grant.
- R6: Ownership passes in the order in which acquires were accepted, whatever the requester indices.
- R7: Acquires accepted in the same cycle receive consecutive tickets, lowest requester index first (ascending order, the default).
- R8: A release from a requester without the grant is ignored: no grant changes. The error output is high for exactly the one cycle after the edge that saw it.
- R9: An acquire from a requester that already holds a ticket is ignored. Its ticket is kept and the dispenser does not advance, so later requesters keep their place in line.
- R10: Both counters wrap modulo 2^TKT_W. TKT_W must be at least log2 of the requester count, and ordering stays correct across any number of wraps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| acq_i | input | N_REQ | Per-requester acquire pulse |
| rel_i | input | N_REQ | Per-requester release pulse |
| grant_o | output | N_REQ | Per-requester lock-held indication |
| bad_rel_o | output | 1 | One-cycle flag for a release from a non-owner |

## Verification
The bench builds the unit with its defaults: four requesters, a three-bit ticket width and ascending order for simultaneous acquires. With only eight ticket values, a few dozen lock hand-offs drive both counters through several wraps, so aliasing bugs show up quickly. All four requesters acquiring in one cycle reaches the worst case of four tickets outstanding at once. Directed scenarios also cover a release and an acquire landing in the same cycle, repeated acquires from waiting and owning requesters, and stray releases both with and without an owner.

// File: rtl/tkt_pkg.sv
package tkt_pkg;
   // Order in which same-cycle acquires are numbered.
   typedef enum logic {
      TKT_ORD_ASCEND  = 1'b0,
      TKT_ORD_DESCEND = 1'b1
   } tkt_order_e;
endpackage

// File: rtl/tkt_dispenser.sv
module tkt_dispenser
   import tkt_pkg::*;
#(
   parameter int         N     = 4,
   parameter int         W     = 3,
   parameter tkt_order_e ORDER = TKT_ORD_ASCEND
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [N-1:0]        take_i,
   output logic [N-1:0][W-1:0] tkt_o,
   output logic [W-1:0]        next_o
);
   logic [W-1:0]        nxt_q;
   logic [W-1:0]        total;
   logic [N-1:0][W-1:0] rank;

   // Rank of each taker among the takers of this cycle.
   generate
      if (ORDER == TKT_ORD_ASCEND) begin : g_asc
         always_comb begin
            for (int i = 0; i < N; i++) begin
               logic [W-1:0] acc;
               acc = '0;
               for (int j = 0; j < i; j++) acc = acc + W'(take_i[j]);
               rank[i] = acc;
            end
         end
      end else begin : g_desc
         always_comb begin
            for (int i = 0; i < N; i++) begin
               logic [W-1:0] acc;
               acc = '0;
               for (int j = i + 1; j < N; j++) acc = acc + W'(take_i[j]);
               rank[i] = acc;
            end
         end
      end
   endgenerate

   always_comb begin
      total = '0;
      for (int k = 0; k < N; k++) total = total + W'(take_i[k]);
   end

   // Fetch-and-add: every taker reads the pre-increment base plus its rank.
   always_ff @(posedge clk) begin
      if (!rst_n) nxt_q <= '0;
      else        nxt_q <= nxt_q + total;
   end

   generate
      for (genvar g = 0; g < N; g++) begin : g_offer
         assign tkt_o[g] = nxt_q + rank[g];
      end
   endgenerate

   assign next_o = nxt_q;
endmodule

// File: rtl/tkt_holder.sv
module tkt_holder #(
   parameter int W = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         take_i,
   input  logic [W-1:0] tkt_i,
   input  logic [W-1:0] serving_i,
   input  logic         rel_i,
   output logic         held_o,
   output logic         grant_o,
   output logic         done_o,
   output logic         stray_o
);
   logic         held_q;
   logic [W-1:0] tkt_q;

   assign grant_o = held_q && (tkt_q == serving_i);
   assign done_o  = rel_i && grant_o;
   assign stray_o = rel_i && !grant_o;
   assign held_o  = held_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held_q <= 1'b0;
         tkt_q  <= '0;
      end else if (take_i) begin
         held_q <= 1'b1;
         tkt_q  <= tkt_i;
      end else if (done_o) begin
         held_q <= 1'b0;
      end
   end
endmodule

// File: rtl/tkt_serve_ctr.sv
module tkt_serve_ctr #(
   parameter int W = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         adv_i,
   output logic [W-1:0] serving_o
);
   logic [W-1:0] srv_q;

   always_ff @(posedge clk) begin
      if (!rst_n)     srv_q <= '0;
      else if (adv_i) srv_q <= srv_q + W'(1);
   end

   assign serving_o = srv_q;
endmodule

// File: rtl/ticket_lock_unit.sv
module ticket_lock_unit
   import tkt_pkg::*;
#(
   parameter int         N_REQ = 4,
   parameter int         TKT_W = $clog2(N_REQ) + 1,
   parameter tkt_order_e ORDER = TKT_ORD_ASCEND
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_REQ-1:0] acq_i,
   input  logic [N_REQ-1:0] rel_i,
   output logic [N_REQ-1:0] grant_o,
   output logic             bad_rel_o
);
   localparam int TKT_SPAN = 1 << TKT_W;

   // Elaboration-time parameter checks.
   generate
      if (N_REQ < 1) begin : g_bad_n
         $error("ticket_lock_unit: N_REQ must be at least 1");
      end
      if (TKT_SPAN < N_REQ) begin : g_bad_w
         $error("ticket_lock_unit: TKT_W too narrow for N_REQ outstanding tickets");
      end
   endgenerate

   logic [N_REQ-1:0]            held;
   logic [N_REQ-1:0]            take;
   logic [N_REQ-1:0]            done;
   logic [N_REQ-1:0]            stray;
   logic [N_REQ-1:0][TKT_W-1:0] tkt_offer;
   logic [TKT_W-1:0]            next_tkt;
   logic [TKT_W-1:0]            srv_q;
   logic                        bad_q;

   // A requester already in line cannot draw a second ticket.
   assign take = acq_i & ~held;

   tkt_dispenser #(.N(N_REQ), .W(TKT_W), .ORDER(ORDER)) u_disp (
      .clk    (clk),
      .rst_n  (rst_n),
      .take_i (take),
      .tkt_o  (tkt_offer),
      .next_o (next_tkt)
   );

   tkt_serve_ctr #(.W(TKT_W)) u_srv (
      .clk       (clk),
      .rst_n     (rst_n),
      .adv_i     (|done),
      .serving_o (srv_q)
   );

   generate
      for (genvar g = 0; g < N_REQ; g++) begin : g_req
         tkt_holder #(.W(TKT_W)) u_hold (
            .clk       (clk),
            .rst_n     (rst_n),
            .take_i    (take[g]),
            .tkt_i     (tkt_offer[g]),
            .serving_i (srv_q),
            .rel_i     (rel_i[g]),
            .held_o    (held[g]),
            .grant_o   (grant_o[g]),
            .done_o    (done[g]),
            .stray_o   (stray[g])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) bad_q <= 1'b0;
      else        bad_q <= |stray;
   end

   assign bad_rel_o = bad_q;
endmodule

// File: rtl/tkt_lock_chk.sv
module tkt_lock_chk #(
   parameter int N = 4,
   parameter int W = 3
) (
   input logic         clk,
   input logic         rst_n,
   input logic [N-1:0] acq,
   input logic [N-1:0] rel,
   input logic [N-1:0] grant,
   input logic         bad,
   input logic [N-1:0] held,
   input logic [W-1:0] srv,
   input logic [W-1:0] nxt
);
   // R4: mutual exclusion
   p_one_owner_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   // R5: a proper release moves service on by exactly one
   p_srv_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (|(rel & grant)) |=> (srv == $past(srv) + W'(1)));

   // R8: service holds when no owner releases
   p_srv_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(|(rel & grant)) |=> $stable(srv));

   // R8: stray release raises the error flag on the next cycle only
   p_bad_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (|(rel & ~grant)) |=> bad);
   p_bad_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(|(rel & ~grant)) |=> !bad);

   // R2 / R9: dispenser advances by the accepted acquires only
   p_disp_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (nxt == $past(nxt) + W'($countones($past(acq & ~held)))));

   // R5: an owner keeps the lock until it releases
   generate
      for (genvar g = 0; g < N; g++) begin : g_keep
         p_grant_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (grant[g] && !rel[g]) |=> grant[g]);
      end
   endgenerate
endmodule

bind ticket_lock_unit tkt_lock_chk #(.N(N_REQ), .W(TKT_W)) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .acq   (acq_i),
   .rel   (rel_i),
   .grant (grant_o),
   .bad   (bad_rel_o),
   .held  (held),
   .srv   (srv_q),
   .nxt   (next_tkt)
);

// File: tb/sim_ticket_lock_unit.sv
module sim_ticket_lock_unit;
   localparam int N = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] acq = '0;
   logic [N-1:0] rel = '0;
   logic [N-1:0] grant;
   logic         bad;
   int           n_chk = 0;
   int           n_fail = 0;
   bit           done = 1'b0;

   always #5 clk = ~clk;

   ticket_lock_unit u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .acq_i     (acq),
      .rel_i     (rel),
      .grant_o   (grant),
      .bad_rel_o (bad)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic go(input logic [N-1:0] a, input logic [N-1:0] r);
      acq = a;
      rel = r;
      tick();
      acq = '0;
      rel = '0;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) tick();
      check("R1 grant in reset", int'(grant), 0);
      rst_n = 1'b1;
      tick();
      check("R1 grant after reset", int'(grant), 0);
      check("R1 error after reset", int'(bad), 0);
   endtask

   task automatic t_single();
      go(4'b0001, 4'b0000);
      check("R1/R3 first acquire granted", int'(grant), 4'b0001);
      go(4'b0000, 4'b0000);
      check("R5 owner keeps grant", int'(grant), 4'b0001);
      go(4'b0000, 4'b0001);
      check("R5 grant drops on release", int'(grant), 0);
      check("R5 no error on owner release", int'(bad), 0);
   endtask

   task automatic t_simul();
      go(4'b1111, 4'b0000);
      check("R7 lowest index first", int'(grant), 4'b0001);
      go(4'b0000, 4'b0001);
      check("R7 second ticket", int'(grant), 4'b0010);
      go(4'b0000, 4'b0010);
      check("R7 third ticket", int'(grant), 4'b0100);
      go(4'b0000, 4'b0100);
      check("R7 fourth ticket", int'(grant), 4'b1000);
      go(4'b0000, 4'b1000);
      check("R5 lock free", int'(grant), 0);
   endtask

   task automatic t_arrival();
      go(4'b1000, 4'b0000);
      go(4'b0010, 4'b0000);
      go(4'b0001, 4'b0000);
      check("R6 first arrival owns", int'(grant), 4'b1000);
      go(4'b0000, 4'b1000);
      check("R6 second arrival", int'(grant), 4'b0010);
      go(4'b0000, 4'b0010);
      check("R6 third arrival", int'(grant), 4'b0001);
      go(4'b0000, 4'b0001);
      check("R6 lock free", int'(grant), 0);
   endtask

   task automatic t_handoff();
      go(4'b0001, 4'b0000);
      go(4'b0010, 4'b0001);
      check("R5 same-cycle acquire and release", int'(grant), 4'b0010);
      go(4'b0000, 4'b0010);
      check("R5 lock free after handoff", int'(grant), 0);
   endtask

   task automatic t_bad_rel();
      go(4'b0000, 4'b0100);
      check("R8 stray release on idle lock", int'(bad), 1);
      check("R8 idle lock stays free", int'(grant), 0);
      go(4'b0001, 4'b0000);
      check("R8 error one cycle only", int'(bad), 0);
      go(4'b0010, 4'b0000);
      go(4'b0000, 4'b0110);
      check("R8 waiter release flagged", int'(bad), 1);
      check("R8 owner unaffected", int'(grant), 4'b0001);
      go(4'b0000, 4'b0001);
      check("R8 waiter kept its place", int'(grant), 4'b0010);
      check("R8 error cleared", int'(bad), 0);
      go(4'b0000, 4'b0010);
      check("R8 lock free", int'(grant), 0);
   endtask

   task automatic t_reacq();
      go(4'b0001, 4'b0000);
      go(4'b0010, 4'b0000);
      go(4'b0010, 4'b0000);
      go(4'b0001, 4'b0000);
      go(4'b0100, 4'b0000);
      check("R9 owner unchanged", int'(grant), 4'b0001);
      go(4'b0000, 4'b0001);
      check("R9 waiter next", int'(grant), 4'b0010);
      go(4'b0000, 4'b0010);
      check("R9 no skipped ticket", int'(grant), 4'b0100);
      go(4'b0000, 4'b0100);
      check("R9 lock free", int'(grant), 0);
   endtask

   task automatic t_wrap();
      for (int r = 0; r < 6; r++) begin
         for (int k = 0; k < N; k++) go(4'(1 << ((r + k) % N)), 4'b0000);
         for (int k = 0; k < N; k++) begin
            check($sformatf("R10 R6 round %0d slot %0d", r, k), int'(grant),
                  1 << ((r + k) % N));
            go(4'b0000, grant);
         end
      end
      go(4'b1111, 4'b0000);
      for (int k = 0; k < N; k++) begin
         check($sformatf("R10 R7 wrapped batch %0d", k), int'(grant), 1 << k);
         go(4'b0000, grant);
      end
      check("R10 lock free", int'(grant), 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog (all) actual=timeout expected=completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_single();
      t_simul();
      t_arrival();
      t_handoff();
      t_bad_rel();
      t_reacq();
      t_wrap();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule